// File: doc/BRIEF.md
# Thresholded Programmable Event Counter

This block is one slice of a performance-monitoring unit. Software programs a 64-bit configuration word and can preset or read a 44-bit accumulating counter through a small register port. Every clock, the slice picks one group of eight sub-event lines from a bank of event groups using an 8-bit event code. It masks that group with an 8-bit sub-event mask and takes the number of set lines as the increment for that cycle.

The increment then passes through a qualifier before it reaches the counter. With a zero threshold, the full increment is added. With a nonzero threshold, a comparator reduces the increment to a 0/1 count, and an invert bit picks the sense of the comparison. Edge-detect mode counts only the cycles in which the qualified activity goes from inactive to active.

Counting needs the local enable bit, an external global enable and a deasserted freeze input. When the counter wraps past its top value, a one-cycle overflow pulse goes to a global status block, but only if the overflow-enable bit is set.

Top module: `evt_cnt_slice`

## Requirements
- R1: Configuration word fields are: event code in bits 7:0, sub-event mask in bits 15:8, edge mode in bit 18, overflow enable in bit 20, local enable in bit 22, invert in bit 23 and threshold in bits 28:24. Every other bit is stored as zero, so writing all ones reads back 0x1FD4FFFF. The register port uses `reg_sel`=0 for the configuration and `reg_sel`=1 for the counter. Reads are combinational, and a write shows on the read port after the next rising edge.
- R2: An event code c below the number of event groups selects `evt_bus[c*8+7:c*8]`. Any larger code gives an increment of zero. The increment is the number of ones in the selected group ANDed with the mask.
- R3: With threshold zero and edge mode clear, the counter advances by the full increment of the cycle.
- R4: With a nonzero threshold and invert clear, the counter advances by one in each cycle whose increment is greater than or equal to the threshold.
- R5: With a nonzero threshold and invert set, the counter advances by one in each cycle whose increment is less than the threshold.
- R6: Activity is defined as follows: with threshold zero it means the increment is nonzero; otherwise it is the comparison result of R4/R5. In edge mode the counter advances by one only in a cycle whose activity is 1 when the previous cycle's activity was 0. The history of activity is tracked every cycle, whether or not counting is enabled.
- R7: The counter changes only when local enable is 1, `glob_en` is 1 and `freeze` is 0. `freeze` leaves the configuration unchanged.
- R8: The counter is 44 bits wide. It wraps modulo 2^44, and bits 63:44 of its read view are zero.
- R9: When an addition carries out of bit 43, `ovf_pulse` is high for exactly the cycle in which the wrapped value appears, and only if overflow enable is set. Otherwise `ovf_pulse` stays low.
- R10: A counter write takes priority over a same-cycle increment: the written value is loaded and no overflow pulse results.
- R11: After reset, the configuration, the counter and `ovf_pulse` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects configuration, 1 selects counter |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register |
| evt_bus | input | NUM_EVT*8 | Event groups, eight sub-event lines each |
| glob_en | input | 1 | External global count enable |
| freeze | input | 1 | Stops counting while high |
| ovf_pulse | output | 1 | One-cycle overflow indication |

## Verification
The hardest case to reach is a wrap of the 44-bit counter, because normal counting would need about 2^44 cycles to get there. The bench instead preloads the counter through the register port a few counts below the top. It then applies full-mask events with the overflow enable both set and clear, and it also writes the counter in a cycle that would otherwise wrap. Edge mode is exercised by random event patterns under several thresholds and invert settings, with counting gated off in between so that the recorded activity history matters.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int CODE_W = 8;
  localparam int MASK_W = 8;
  localparam int THR_W  = 5;
  localparam logic [63:0] CFG_WMASK = 64'h0000_0000_1FD4_FFFF;

  typedef struct packed {
    logic [THR_W-1:0]  thr;
    logic              inv;
    logic              loc_en;
    logic              ovf_en;
    logic              edge_md;
    logic [MASK_W-1:0] mask;
    logic [CODE_W-1:0] code;
  } cfg_t;

  function automatic cfg_t unpack_cfg(input logic [63:0] w);
    cfg_t c;
    c.code    = w[7:0];
    c.mask    = w[15:8];
    c.edge_md = w[18];
    c.ovf_en  = w[20];
    c.loc_en  = w[22];
    c.inv     = w[23];
    c.thr     = w[28:24];
    return c;
  endfunction

  function automatic logic [63:0] pack_cfg(input cfg_t c);
    logic [63:0] w;
    w        = '0;
    w[7:0]   = c.code;
    w[15:8]  = c.mask;
    w[18]    = c.edge_md;
    w[20]    = c.ovf_en;
    w[22]    = c.loc_en;
    w[23]    = c.inv;
    w[28:24] = c.thr;
    return w;
  endfunction
endpackage

// File: rtl/evt_select.sv
module evt_select #(
  parameter int NUM_EVT = 4,
  parameter int SUB_W   = 8,
  parameter int CODE_W  = 8,
  parameter int INC_W   = $clog2(SUB_W + 1)
) (
  input  logic [NUM_EVT*SUB_W-1:0] evt_bus,
  input  logic [CODE_W-1:0]        code,
  input  logic [SUB_W-1:0]         mask,
  output logic [INC_W-1:0]         inc
);
  logic [INC_W-1:0] grp_cnt [NUM_EVT];

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_grp
    always_comb begin
      grp_cnt[g] = '0;
      for (int b = 0; b < SUB_W; b++) begin
        grp_cnt[g] = grp_cnt[g] + INC_W'(evt_bus[g*SUB_W+b] & mask[b]);
      end
    end
  end

  always_comb begin
    inc = '0;
    for (int g = 0; g < NUM_EVT; g++) begin
      if (32'(code) == g) inc = grp_cnt[g];
    end
  end
endmodule

// File: rtl/evt_qualify.sv
module evt_qualify #(
  parameter int INC_W = 4,
  parameter int THR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  input  logic [THR_W-1:0] thr,
  input  logic             inv,
  input  logic             edge_md,
  output logic [INC_W-1:0] add_amt
);
  localparam int CMP_W = (INC_W > THR_W) ? INC_W : THR_W;

  logic act, prev_q, prev_d, ge_thr;

  always_comb begin
    ge_thr = CMP_W'(inc) >= CMP_W'(thr);
    if (thr == '0) act = (inc != '0);
    else           act = inv ? !ge_thr : ge_thr;
    prev_d = act;
    if (edge_md)          add_amt = INC_W'(act && !prev_q);
    else if (thr == '0)   add_amt = inc;
    else                  add_amt = INC_W'(act);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  // R6: after a counted edge, no second count while the comparison is unchanged
  p_edge_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_md && add_amt != '0) |=>
      (!edge_md || thr != $past(thr) || inv != $past(inv) || add_amt == '0));
endmodule

// File: rtl/evt_accum.sv
module evt_accum #(
  parameter int CNT_W = 44,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [INC_W-1:0] add_amt,
  input  logic             ovf_en,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_pulse
);
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   sum;
  logic             ovf_d, cnt_ce;

  always_comb begin
    sum    = {1'b0, cnt} + (CNT_W+1)'(add_amt);
    cnt_ce = wr || cnt_en;
    cnt_d  = cnt;
    ovf_d  = 1'b0;
    if (wr) begin
      cnt_d = wdata;
    end else if (cnt_en) begin
      cnt_d = sum[CNT_W-1:0];
      ovf_d = sum[CNT_W] && ovf_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= ovf_d;
      if (cnt_ce) cnt <= cnt_d;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr) |=> $stable(cnt));
  p_wr_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt == $past(wdata) && !ovf_pulse));
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_en |=> !ovf_pulse);
  p_wrap_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (cnt < CNT_W'(1 << INC_W)));
endmodule

// File: rtl/evt_cnt_slice.sv
module evt_cnt_slice
  import evt_cnt_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int CNT_W   = 44
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic                    reg_sel,
  input  logic [63:0]             reg_wdata,
  output logic [63:0]             reg_rdata,
  input  logic [NUM_EVT*MASK_W-1:0] evt_bus,
  input  logic                    glob_en,
  input  logic                    freeze,
  output logic                    ovf_pulse
);
  localparam int SUB_W = MASK_W;
  localparam int INC_W = $clog2(SUB_W + 1);

  logic rst_q1, rst_q2, rst_s;
  cfg_t cfg_q, cfg_d;
  logic cfg_ce, cnt_wr, cnt_en;
  logic [INC_W-1:0] inc, add_amt;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end
  assign rst_s = rst_q2;

  always_comb begin
    cfg_ce = reg_wr && !reg_sel;
    cnt_wr = reg_wr && reg_sel;
    cfg_d  = unpack_cfg(reg_wdata);
    cnt_en = cfg_q.loc_en && glob_en && !freeze;
    reg_rdata = reg_sel ? 64'(cnt) : pack_cfg(cfg_q);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      cfg_q <= '0;
    else if (cfg_ce) cfg_q <= cfg_d;
  end

  evt_select #(.NUM_EVT(NUM_EVT), .SUB_W(SUB_W), .CODE_W(CODE_W), .INC_W(INC_W)) u_sel (
    .evt_bus (evt_bus),
    .code    (cfg_q.code),
    .mask    (cfg_q.mask),
    .inc     (inc)
  );

  evt_qualify #(.INC_W(INC_W), .THR_W(THR_W)) u_qual (
    .clk     (clk),
    .rst_n   (rst_s),
    .inc     (inc),
    .thr     (cfg_q.thr),
    .inv     (cfg_q.inv),
    .edge_md (cfg_q.edge_md),
    .add_amt (add_amt)
  );

  evt_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_s),
    .cnt_en    (cnt_en),
    .add_amt   (add_amt),
    .ovf_en    (cfg_q.ovf_en),
    .wr        (cnt_wr),
    .wdata     (reg_wdata[CNT_W-1:0]),
    .cnt       (cnt),
    .ovf_pulse (ovf_pulse)
  );

  p_cfg_keep_r7: assert property (@(posedge clk) disable iff (!rst_s)
    !(reg_wr && !reg_sel) |=> $stable(cfg_q));
  p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (32'(cfg_q.code) >= NUM_EVT) |-> (inc == '0));
endmodule

// File: tb/evt_cnt_slice_tb_top.sv
module evt_cnt_slice_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int EW = NE * 8;

  logic clk = 1'b0;
  logic rst_n, reg_wr, reg_sel, glob_en, freeze;
  logic [63:0] reg_wdata, reg_rdata;
  logic [EW-1:0] evt_bus;
  logic ovf_pulse;

  int total = 0, bad = 0;
  bit done = 0;

  logic [63:0] m_cfg;
  logic [43:0] m_cnt;
  logic m_prev, m_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_cnt_slice #(.NUM_EVT(NE), .CNT_W(44)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_bus(evt_bus),
    .glob_en(glob_en), .freeze(freeze), .ovf_pulse(ovf_pulse)
  );

  function automatic logic [63:0] mk(input int code, input int mask, input bit edg,
                                     input bit oen, input bit len, input bit inv, input int thr);
    logic [63:0] w;
    w = '0;
    w[7:0] = 8'(code); w[15:8] = 8'(mask); w[18] = edg; w[20] = oen;
    w[22] = len; w[23] = inv; w[28:24] = 5'(thr);
    return w;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit wr, input bit sel, input logic [63:0] wd,
                      input bit ge, input bit fz, input logic [EW-1:0] ev);
    int code, inc, thr;
    bit act, len, addo;
    logic [44:0] sum;
    int add;
    check({tag, " rdata"}, reg_rdata, reg_sel ? {20'b0, m_cnt} : m_cfg);
    check({tag, " ovf"}, {63'b0, ovf_pulse}, {63'b0, m_ovf});
    reg_wr = wr; reg_sel = sel; reg_wdata = wd; glob_en = ge; freeze = fz; evt_bus = ev;
    code = int'(m_cfg[7:0]);
    thr  = int'(m_cfg[28:24]);
    inc  = (code < NE) ? $countones(ev[code*8 +: 8] & m_cfg[15:8]) : 0;
    if (thr == 0) act = (inc != 0);
    else          act = m_cfg[23] ? (inc < thr) : (inc >= thr);
    if (m_cfg[18])     add = (act && !m_prev) ? 1 : 0;
    else if (thr == 0) add = inc;
    else               add = act ? 1 : 0;
    len = m_cfg[22];
    m_ovf = 1'b0;
    if (wr && sel) m_cnt = wd[43:0];
    else if (len && ge && !fz) begin
      sum = {1'b0, m_cnt} + 45'(add);
      addo = sum[44];
      m_ovf = addo && m_cfg[20];
      m_cnt = sum[43:0];
    end
    m_prev = act;
    if (wr && !sel) m_cfg = wd & 64'h1FD4_FFFF;
    @(negedge clk);
  endtask

  task automatic run_rand(input string tag, input logic [63:0] cfg, input int n,
                          input bit ge, input bit fz, input int dens);
    step(tag, 1, 0, cfg, ge, fz, '0);
    for (int i = 0; i < n; i++) begin
      logic [EW-1:0] ev;
      ev = '0;
      for (int b = 0; b < EW; b++) ev[b] = (($urandom % 100) < dens);
      step(tag, 0, $urandom % 2, '0, ge, fz, ev);
    end
  endtask

  initial begin
    rst_n = 0; reg_wr = 0; reg_sel = 0; reg_wdata = '0; glob_en = 0; freeze = 0; evt_bus = '0;
    m_cfg = '0; m_cnt = '0; m_prev = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    check("R11 cfg reset", reg_rdata, 64'h0);
    reg_sel = 1; #1;
    check("R11 cnt reset", reg_rdata, 64'h0);
    check("R11 ovf reset", {63'b0, ovf_pulse}, 64'h0);
    reg_sel = 0;
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reserved bits dropped, fields kept
    step("R1", 1, 0, '1, 0, 0, '0);
    check("R1 masked readback", reg_rdata, 64'h1FD4_FFFF);
    step("R1", 0, 0, '0, 0, 0, '0);

    // R3: level, threshold zero, full increment
    run_rand("R3", mk(0, 8'hFF, 0, 0, 1, 0, 0), 60, 1, 0, 50);
    run_rand("R3", mk(2, 8'h5A, 0, 0, 1, 0, 0), 60, 1, 0, 40);
    // R2: codes in and out of range
    for (int c = 0; c < 8; c++)
      run_rand("R2", mk(c, $urandom % 256, 0, 0, 1, 0, 0), 20, 1, 0, 60);
    // R4 / R5: thresholds
    for (int t = 1; t < 10; t++) begin
      run_rand("R4", mk(1, 8'hFF, 0, 0, 1, 0, t), 30, 1, 0, 50);
      run_rand("R5", mk(3, 8'hF7, 0, 0, 1, 1, t), 30, 1, 0, 50);
    end
    // R6: edge mode with several thresholds, counting gated at times
    for (int t = 0; t < 6; t++) begin
      run_rand("R6", mk(0, 8'hFF, 1, 0, 1, t % 2, t), 40, 1, 0, 30);
      run_rand("R6", mk(0, 8'hFF, 1, 0, 1, 0, t), 20, 0, 0, 30);
      run_rand("R6", mk(0, 8'hFF, 1, 0, 1, 0, t), 20, 1, 0, 30);
    end
    // R7: global enable off, freeze on, local enable off
    run_rand("R7", mk(0, 8'hFF, 0, 1, 1, 0, 0), 30, 0, 0, 50);
    run_rand("R7", mk(0, 8'hFF, 0, 1, 1, 0, 0), 30, 1, 1, 50);
    run_rand("R7", mk(0, 8'hFF, 0, 1, 0, 0, 0), 30, 1, 0, 50);

    // R8 / R9: wrap with overflow enable set
    step("R9", 1, 0, mk(0, 8'hFF, 0, 1, 1, 0, 0), 0, 0, '0);
    step("R9", 1, 1, 64'h0000_0FFF_FFFF_FFFB, 0, 0, '0);
    step("R9", 0, 1, '0, 1, 0, '1);
    check("R8 wrapped value", reg_rdata, 64'h3);
    check("R9 pulse", {63'b0, ovf_pulse}, 64'h1);
    step("R9", 0, 1, '0, 0, 0, '0);
    check("R9 pulse one cycle", {63'b0, ovf_pulse}, 64'h0);
    // R9: overflow enable clear, wrap gives no pulse
    step("R9", 1, 0, mk(0, 8'hFF, 0, 0, 1, 0, 0), 0, 0, '0);
    step("R9", 1, 1, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, '0);
    check("R8 upper bits zero", reg_rdata, 64'h0000_0FFF_FFFF_FFFE);
    step("R9", 0, 1, '0, 1, 0, '1);
    check("R9 gated pulse", {63'b0, ovf_pulse}, 64'h0);
    // R10: write beats a wrapping increment
    step("R10", 1, 0, mk(0, 8'hFF, 0, 1, 1, 0, 0), 0, 0, '0);
    step("R10", 1, 1, 64'h0000_0FFF_FFFF_FFFF, 0, 0, '0);
    step("R10", 1, 1, 64'h0000_0000_0000_0123, 1, 0, '1);
    check("R10 written value", reg_rdata, 64'h123);
    check("R10 no pulse", {63'b0, ovf_pulse}, 64'h0);
    for (int i = 0; i < 40; i++)
      step("R10", ($urandom % 4) == 0, 1, 64'($urandom), 1, 0, EW'($urandom));
    step("R10", 0, 1, '0, 0, 0, '0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule